// File: doc/BRIEF.md
# IDE CDROM Select and Interrupt Mapper

This block sits between an ISA I/O address bus and an external IDE CDROM drive. It decodes the bus address into two active-low selects for the drive. The main select covers an eight-byte task-file window. The alternate select covers a status window of one to eight bytes. The drive's interrupt reaches the bus with a polarity that software can program. The drive's DMA request goes to the bus, and the bus DMA acknowledge goes back to the drive.

The drive signals share package pins with other functions. Four pins carry upper address bits 15..12 by default. They take the drive roles only when a strap input, captured during reset, asks for it. A fifth pin is shared three ways. A volume-down button has first claim on it, the alternate select comes second, and a plain auxiliary output comes last. Pins are modelled as separate in, out and output-enable signals.

Top module: `cdrom_pinmux`

## Requirements
- R1: In drive mode, mf_out[0] is low exactly when isa_aen is low and isa_addr lies in the 8-byte block that contains the main base register, the base being aligned down to 8.
- R2: The alternate window size code c in control bits [4:2] selects c+1 bytes. The window starts at the alternate base aligned down to the smallest power of two that is at least c+1. When the shared pin is in alternate-select role, sh_out is low exactly when isa_aen is low and the address is in that window.
- R3: While isa_aen is high, neither select is asserted, whatever the address.
- R4: After reset the main base is 0x170, the alternate base is 0x376, the size code is 0 (one byte), control bit 0 (interrupt active-high) is 1, and control bit 1 (volume enable) is 0.
- R5: In drive mode with control bit 0 set, isa_irq follows mf_in[1]. With control bit 0 clear, isa_irq is the inverse of mf_in[1].
- R6: In drive mode, isa_drq follows mf_in[2] and mf_out[3] follows isa_dack_n. mf_oe is 4'b1001, so pins 1 and 2 are inputs.
- R7: In default mode (drive strap captured low), mf_oe is 4'b1111 and mf_out equals isa_addr[15:12]. isa_irq and isa_drq stay low.
- R8: Both straps are sampled on every clock while rst_n is low. After release they hold, and later strap changes have no effect until the next reset.
- R9: With volume enable set, the shared pin is an input (sh_oe low) and vol_down is the inverse of sh_in. With volume enable clear, the alternate-select strap makes sh_out carry the alternate select. Otherwise sh_out carries aux_ctl. In both of those cases sh_oe is high and vol_down is low.
- R10: A write with cfg_we high loads a register at the clock edge, and its effect shows from the next cycle. cfg_addr 0 loads the main base, 1 the alternate base, 2 the control bits [4:0], and 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while low |
| strap_drive | input | 1 | Strap: four pins take the drive roles |
| strap_alt | input | 1 | Strap: shared pin may carry the alternate select |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 16 | Write data |
| isa_addr | input | 16 | ISA I/O address |
| isa_aen | input | 1 | Address enable, high during DMA cycles |
| isa_dack_n | input | 1 | Bus DMA acknowledge, active low |
| isa_irq | output | 1 | Interrupt toward the bus, active high |
| isa_drq | output | 1 | DMA request toward the bus |
| mf_in | input | 4 | Multi-function pin input levels |
| mf_out | output | 4 | Multi-function pin output values |
| mf_oe | output | 4 | Multi-function pin output enables |
| sh_in | input | 1 | Shared pin input level |
| sh_out | output | 1 | Shared pin output value |
| sh_oe | output | 1 | Shared pin output enable |
| aux_ctl | input | 1 | Value for the shared pin in its auxiliary role |
| vol_down | output | 1 | Volume-down press, active high |

## Verification
A table of addresses is applied in turn: the first and last byte of each window, the bytes just outside each window, the same offsets with an upper address bit flipped, and hits with isa_aen raised. This separates an off-by-one window edge, a missing compare on the high bits, and a missing isa_aen qualifier. The size codes 1, 2, 4 and 7 are then tried with aligned and unaligned bases, which tells a wrong alignment mask apart from a wrong length compare. Three strap patterns (both set, drive only, none) and strap changes made after release show that pin roles come from the captured straps, and that volume enable takes the shared pin first.

// File: rtl/cdm_pkg.sv
`timescale 1ns/1ps
package cdm_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned PIN_N  = 4;

  typedef struct packed {
    logic [CODE_W-1:0] alt_code;
    logic              vol_en;
    logic              irq_hi;
  } ctl_t;

  localparam int unsigned CTL_W = $bits(ctl_t);

  typedef enum logic [1:0] {
    SH_AUX = 2'd0,
    SH_ALT = 2'd1,
    SH_VOL = 2'd2
  } sh_role_e;

  localparam logic [1:0] REG_PRI = 2'd0;
  localparam logic [1:0] REG_ALT = 2'd1;
  localparam logic [1:0] REG_CTL = 2'd2;
endpackage

// File: rtl/cdm_cfg_regs.sv
`timescale 1ns/1ps
module cdm_cfg_regs
  import cdm_pkg::*;
#(
  parameter int unsigned      ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] PRI_RST = 16'h0170,
  parameter logic [ADDR_W-1:0] ALT_RST = 16'h0376
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] pri_base,
  output logic [ADDR_W-1:0] alt_base,
  output ctl_t              ctl
);
  localparam ctl_t CTL_RST = '{alt_code: '0, vol_en: 1'b0, irq_hi: 1'b1};

  logic wr_pri, wr_alt, wr_ctl;
  assign wr_pri = cfg_we && (cfg_addr == REG_PRI);
  assign wr_alt = cfg_we && (cfg_addr == REG_ALT);
  assign wr_ctl = cfg_we && (cfg_addr == REG_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_base <= PRI_RST;
      alt_base <= ALT_RST;
      ctl      <= CTL_RST;
    end else begin
      if (wr_pri) pri_base <= cfg_wdata;
      if (wr_alt) alt_base <= cfg_wdata;
      if (wr_ctl) ctl      <= ctl_t'(cfg_wdata[CTL_W-1:0]);
    end
  end

  a_r4_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pri_base == PRI_RST) && (alt_base == ALT_RST) && (ctl == CTL_RST));

  a_r10_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> ctl == ctl_t'($past(cfg_wdata[CTL_W-1:0])));

  a_r10_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pri |=> pri_base == $past(cfg_wdata));
endmodule

// File: rtl/cdm_strap_latch.sv
`timescale 1ns/1ps
module cdm_strap_latch #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strap_in,
  output logic [N-1:0] strap_q
);
  // sampled continuously while reset is held; frozen once it is released
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_in;
  end

  a_r8_straps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));
endmodule

// File: rtl/cdm_decode.sv
`timescale 1ns/1ps
module cdm_decode
  import cdm_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PRI_LG = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] isa_addr,
  input  logic              isa_aen,
  input  logic [ADDR_W-1:0] pri_base,
  input  logic [ADDR_W-1:0] alt_base,
  input  logic [CODE_W-1:0] alt_code,
  output logic              pri_hit,
  output logic              alt_hit,
  output logic              pri_sel_n,
  output logic              alt_sel_n
);
  // mask of the offset bits: smallest 2^k - 1 that covers the size code
  function automatic logic [ADDR_W-1:0] span_mask(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] m;
    m = code;
    for (int s = 1; s < CODE_W; s++) m = m | (code >> s);
    return ADDR_W'(m);
  endfunction

  function automatic logic in_alt(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] b,
                                  input logic [CODE_W-1:0] code);
    logic [ADDR_W-1:0] m;
    m = span_mask(code);
    return ((a & ~m) == (b & ~m)) && ((a & m) <= ADDR_W'(code));
  endfunction

  function automatic logic in_pri(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:PRI_LG] == b[ADDR_W-1:PRI_LG];
  endfunction

  assign pri_hit   = in_pri(isa_addr, pri_base);
  assign alt_hit   = in_alt(isa_addr, alt_base, alt_code);
  assign pri_sel_n = ~(pri_hit && !isa_aen);
  assign alt_sel_n = ~(alt_hit && !isa_aen);

  a_r1_pri_block: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_sel_n |-> (isa_addr >= pri_base - (pri_base % (ADDR_W'(1) << PRI_LG))));
  a_r2_alt_len: assert property (@(posedge clk) disable iff (!rst_n)
    !alt_sel_n |-> ((isa_addr - (alt_base & ~span_mask(alt_code))) <= ADDR_W'(alt_code)));
endmodule

// File: rtl/cdm_pin_mux.sv
`timescale 1ns/1ps
module cdm_pin_mux
  import cdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_mode,
  input  logic             alt_strap,
  input  logic             vol_en,
  input  logic             irq_hi,
  input  logic             pri_sel_n,
  input  logic             alt_sel_n,
  input  logic [PIN_N-1:0] addr_hi,
  input  logic             isa_dack_n,
  input  logic [PIN_N-1:0] mf_in,
  input  logic             sh_in,
  input  logic             aux_ctl,
  output logic [PIN_N-1:0] mf_out,
  output logic [PIN_N-1:0] mf_oe,
  output logic             isa_irq,
  output logic             isa_drq,
  output logic             sh_out,
  output logic             sh_oe,
  output logic             vol_down
);
  // pin 0 select out, pin 1 interrupt in, pin 2 request in, pin 3 acknowledge out
  localparam logic [PIN_N-1:0] DRIVE_OE = 4'b1001;

  logic             dack_to_drive;
  logic [PIN_N-1:0] drive_val;
  sh_role_e         sh_role;

  assign dack_to_drive = drive_mode ? isa_dack_n : 1'b1;
  assign drive_val     = {dack_to_drive, 1'b1, 1'b1, pri_sel_n};

  assign isa_irq = drive_mode && (irq_hi ? mf_in[1] : ~mf_in[1]);
  assign isa_drq = drive_mode && mf_in[2];

  for (genvar p = 0; p < PIN_N; p++) begin : g_pin
    assign mf_out[p] = drive_mode ? drive_val[p] : addr_hi[p];
    assign mf_oe[p]  = drive_mode ? DRIVE_OE[p]  : 1'b1;
  end

  always_comb begin
    if (vol_en)         sh_role = SH_VOL;
    else if (alt_strap) sh_role = SH_ALT;
    else                sh_role = SH_AUX;
  end

  always_comb begin
    sh_out   = aux_ctl;
    sh_oe    = 1'b1;
    vol_down = 1'b0;
    case (sh_role)
      SH_VOL: begin
        sh_out   = 1'b1;
        sh_oe    = 1'b0;
        vol_down = ~sh_in;
      end
      SH_ALT:  sh_out = alt_sel_n;
      default: sh_out = aux_ctl;
    endcase
  end

  a_r9_vol_owns_pin: assert property (@(posedge clk) disable iff (!rst_n)
    vol_en |-> !sh_oe);
  a_r9_quiet_button: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_en |-> !vol_down);
  a_r7_default_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_mode |-> !isa_irq && !isa_drq && (mf_oe == '1));
  a_r6_drive_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    drive_mode |-> !mf_oe[1] && !mf_oe[2]);
endmodule

// File: rtl/cdrom_pinmux.sv
`timescale 1ns/1ps
module cdrom_pinmux
  import cdm_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter int unsigned       PRI_LG  = 3,
  parameter logic [ADDR_W-1:0] PRI_RST = 16'h0170,
  parameter logic [ADDR_W-1:0] ALT_RST = 16'h0376
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_drive,
  input  logic              strap_alt,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] isa_addr,
  input  logic              isa_aen,
  input  logic              isa_dack_n,
  output logic              isa_irq,
  output logic              isa_drq,
  input  logic [3:0]        mf_in,
  output logic [3:0]        mf_out,
  output logic [3:0]        mf_oe,
  input  logic              sh_in,
  output logic              sh_out,
  output logic              sh_oe,
  input  logic              aux_ctl,
  output logic              vol_down
);
  localparam int unsigned HI_LSB = ADDR_W - PIN_N;

  logic [ADDR_W-1:0] pri_base, alt_base;
  ctl_t              ctl;
  logic [1:0]        strap_q;
  logic              drive_mode, alt_strap;
  logic              pri_hit, alt_hit, pri_sel_n, alt_sel_n;

  cdm_cfg_regs #(.ADDR_W(ADDR_W), .PRI_RST(PRI_RST), .ALT_RST(ALT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pri_base(pri_base), .alt_base(alt_base), .ctl(ctl)
  );

  cdm_strap_latch #(.N(2)) u_straps (
    .clk(clk), .rst_n(rst_n), .strap_in({strap_alt, strap_drive}), .strap_q(strap_q)
  );
  assign drive_mode = strap_q[0];
  assign alt_strap  = strap_q[1];

  cdm_decode #(.ADDR_W(ADDR_W), .PRI_LG(PRI_LG)) u_dec (
    .clk(clk), .rst_n(rst_n), .isa_addr(isa_addr), .isa_aen(isa_aen),
    .pri_base(pri_base), .alt_base(alt_base), .alt_code(ctl.alt_code),
    .pri_hit(pri_hit), .alt_hit(alt_hit), .pri_sel_n(pri_sel_n), .alt_sel_n(alt_sel_n)
  );

  cdm_pin_mux u_mux (
    .clk(clk), .rst_n(rst_n), .drive_mode(drive_mode), .alt_strap(alt_strap),
    .vol_en(ctl.vol_en), .irq_hi(ctl.irq_hi), .pri_sel_n(pri_sel_n),
    .alt_sel_n(alt_sel_n), .addr_hi(isa_addr[ADDR_W-1:HI_LSB]),
    .isa_dack_n(isa_dack_n), .mf_in(mf_in), .sh_in(sh_in), .aux_ctl(aux_ctl),
    .mf_out(mf_out), .mf_oe(mf_oe), .isa_irq(isa_irq), .isa_drq(isa_drq),
    .sh_out(sh_out), .sh_oe(sh_oe), .vol_down(vol_down)
  );

  a_r3_aen_blocks_main: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_aen && drive_mode) |-> mf_out[0]);
  a_r3_aen_blocks_alt: assert property (@(posedge clk) disable iff (!rst_n)
    (isa_aen && alt_strap && !ctl.vol_en) |-> sh_out);
endmodule

// File: tb/test_cdrom_pinmux.sv
`timescale 1ns/1ps
module test_cdrom_pinmux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_drive = 1'b1, strap_alt = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] isa_addr = '0;
  logic        isa_aen = 1'b0, isa_dack_n = 1'b1;
  logic        isa_irq, isa_drq;
  logic [3:0]  mf_in = '0, mf_out, mf_oe;
  logic        sh_in = 1'b1, sh_out, sh_oe, aux_ctl = 1'b0, vol_down;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cdrom_pinmux i_cdrom_pinmux (
    .clk(clk), .rst_n(rst_n), .strap_drive(strap_drive), .strap_alt(strap_alt),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .isa_addr(isa_addr), .isa_aen(isa_aen), .isa_dack_n(isa_dack_n),
    .isa_irq(isa_irq), .isa_drq(isa_drq), .mf_in(mf_in), .mf_out(mf_out),
    .mf_oe(mf_oe), .sh_in(sh_in), .sh_out(sh_out), .sh_oe(sh_oe),
    .aux_ctl(aux_ctl), .vol_down(vol_down)
  );

  // {address, aen, expected main select_n, expected alternate select_n}
  localparam logic [18:0] VEC [12] = '{
    {16'h01F0, 1'b0, 1'b0, 1'b1},
    {16'h01F7, 1'b0, 1'b0, 1'b1},
    {16'h01EF, 1'b0, 1'b1, 1'b1},
    {16'h01F8, 1'b0, 1'b1, 1'b1},
    {16'h01F3, 1'b1, 1'b1, 1'b1},
    {16'h03F6, 1'b0, 1'b1, 1'b0},
    {16'h03F7, 1'b0, 1'b1, 1'b0},
    {16'h03F5, 1'b0, 1'b1, 1'b1},
    {16'h03F8, 1'b0, 1'b1, 1'b1},
    {16'h03F6, 1'b1, 1'b1, 1'b1},
    {16'h11F0, 1'b0, 1'b1, 1'b1},
    {16'h13F6, 1'b0, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h, want %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic sd, input logic sa);
    @(negedge clk);
    rst_n = 1'b0; strap_drive = sd; strap_alt = sa;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a, input logic aen);
    @(negedge clk);
    isa_addr = a; isa_aen = aen;
    #1;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: got hang, want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset state, both straps set (R4)
    do_reset(1'b1, 1'b1);
    probe(16'h0170, 1'b0); check("R4 main base", 16'(mf_out[0]), 16'h0);
    probe(16'h0177, 1'b0); check("R4 main end",  16'(mf_out[0]), 16'h0);
    probe(16'h0178, 1'b0); check("R4 main past", 16'(mf_out[0]), 16'h1);
    probe(16'h0376, 1'b0); check("R4 alt 1 byte", 16'(sh_out), 16'h0);
    probe(16'h0377, 1'b0); check("R4 alt size 1", 16'(sh_out), 16'h1);
    mf_in = 4'b0010; #1;   check("R4 irq active-high", 16'(isa_irq), 16'h1);
    mf_in = 4'b0000; #1;   check("R4 irq idle", 16'(isa_irq), 16'h0);
    check("R6 drive pin dirs", 16'(mf_oe), 16'h9);
    check("R9 shared drives", 16'(sh_oe), 16'h1);

    // R10 programming, then the address table (R1 R2 R3)
    wr(2'd0, 16'h01F0);
    wr(2'd1, 16'h03F6);
    wr(2'd2, 16'h0005);
    wr(2'd3, 16'h0000);
    for (int i = 0; i < 12; i++) begin
      probe(VEC[i][18:3], VEC[i][2]);
      check($sformatf("R1 vec %0d", i), 16'(mf_out[0]), 16'(VEC[i][1]));
      check($sformatf("R2 R3 vec %0d", i), 16'(sh_out), 16'(VEC[i][0]));
    end

    // size codes and alignment (R2), unaligned main base (R1)
    wr(2'd1, 16'h03F0); wr(2'd2, 16'h001D);
    probe(16'h03F0, 1'b0); check("R2 c7 first", 16'(sh_out), 16'h0);
    probe(16'h03F7, 1'b0); check("R2 c7 last",  16'(sh_out), 16'h0);
    probe(16'h03EF, 1'b0); check("R2 c7 below", 16'(sh_out), 16'h1);
    probe(16'h03F8, 1'b0); check("R2 c7 above", 16'(sh_out), 16'h1);
    wr(2'd1, 16'h03F4); wr(2'd2, 16'h0009);
    probe(16'h03F4, 1'b0); check("R2 c2 first", 16'(sh_out), 16'h0);
    probe(16'h03F6, 1'b0); check("R2 c2 last",  16'(sh_out), 16'h0);
    probe(16'h03F7, 1'b0); check("R2 c2 past",  16'(sh_out), 16'h1);
    probe(16'h03F3, 1'b0); check("R2 c2 below", 16'(sh_out), 16'h1);
    wr(2'd1, 16'h03F3); wr(2'd2, 16'h0011);
    probe(16'h03F0, 1'b0); check("R2 c4 aligned down", 16'(sh_out), 16'h0);
    probe(16'h03F4, 1'b0); check("R2 c4 last", 16'(sh_out), 16'h0);
    probe(16'h03F5, 1'b0); check("R2 c4 past", 16'(sh_out), 16'h1);
    wr(2'd0, 16'h01F3);
    probe(16'h01F0, 1'b0); check("R1 unaligned base", 16'(mf_out[0]), 16'h0);
    probe(16'h01F7, 1'b0); check("R1 unaligned end",  16'(mf_out[0]), 16'h0);

    // polarity (R5)
    wr(2'd2, 16'h0000);
    mf_in = 4'b0000; #1; check("R5 active-low asserted", 16'(isa_irq), 16'h1);
    mf_in = 4'b0010; #1; check("R5 active-low idle", 16'(isa_irq), 16'h0);
    wr(2'd2, 16'h0001);
    #1; check("R5 active-high again", 16'(isa_irq), 16'h1);

    // DMA pass-through (R6)
    mf_in = 4'b0100; #1; check("R6 drq high", 16'(isa_drq), 16'h1);
    mf_in = 4'b0000; #1; check("R6 drq low",  16'(isa_drq), 16'h0);
    isa_dack_n = 1'b0; #1; check("R6 dack low",  16'(mf_out[3]), 16'h0);
    isa_dack_n = 1'b1; #1; check("R6 dack high", 16'(mf_out[3]), 16'h1);

    // volume precedence (R9): alt base 0x3F3, one byte
    wr(2'd2, 16'h0003);
    probe(16'h03F3, 1'b0); check("R9 vol input", 16'(sh_oe), 16'h0);
    sh_in = 1'b0; #1; check("R9 press", 16'(vol_down), 16'h1);
    sh_in = 1'b1; #1; check("R9 release", 16'(vol_down), 16'h0);
    wr(2'd2, 16'h0001);
    probe(16'h03F3, 1'b0); check("R9 alt returns", 16'(sh_out), 16'h0);
    check("R9 alt drives", 16'(sh_oe), 16'h1);

    // drive strap only: shared pin auxiliary (R9, R8)
    do_reset(1'b1, 1'b0);
    aux_ctl = 1'b1; probe(16'h0376, 1'b0); check("R9 aux high", 16'(sh_out), 16'h1);
    aux_ctl = 1'b0; #1; check("R9 aux low", 16'(sh_out), 16'h0);
    check("R9 aux no button", 16'(vol_down), 16'h0);

    // no straps: default pin roles (R7), strap changes afterwards ignored (R8)
    do_reset(1'b0, 1'b0);
    probe(16'hA5F0, 1'b0); check("R7 pins drive", 16'(mf_oe), 16'hF);
    check("R7 addr hi A", 16'(mf_out), 16'hA);
    probe(16'h5170, 1'b0); check("R7 addr hi 5", 16'(mf_out), 16'h5);
    mf_in = 4'b1111; #1;
    check("R7 irq quiet", 16'(isa_irq), 16'h0);
    check("R7 drq quiet", 16'(isa_drq), 16'h0);
    strap_drive = 1'b1; strap_alt = 1'b1;
    repeat (4) @(negedge clk);
    #1; check("R8 strap held", 16'(mf_oe), 16'hF);
    check("R8 strap held irq", 16'(isa_irq), 16'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule